// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel. It moves data between a peripheral that sits at a fixed address and a buffer in memory whose address steps forward. Software can program the channel registers directly. It can also point the channel at a chain of five-word descriptors in memory. In that case the channel fetches a new descriptor by itself each time the current transfer count runs out. A zero link ends the chain. A link that points back to an earlier descriptor forms a ring that never ends.

The peripheral paces the transfer with a level request. For each transfer unit the channel:

- reads one unit from the source address over a simple bus,
- writes that unit to the destination address,
- acknowledges the peripheral in the cycle of that write.

A descriptor can ask for a one-cycle terminal-count pulse when it finishes. Software controls the run through three things:

- a halt bit, which lets the unit in flight drain,
- an active flag, which shows when that drain is over,
- the enable bit, which can be cleared to abort at once.

Top module: `llDmaChannel`

## Requirements
- R1: After reset every channel register reads zero, and `busReq`, `perAck` and `tcPulse` are low.
- R2: Registers sit at `regAddr` 0 source, 1 destination, 2 link, 3 control A, 4 count and 5 config. Every register reads back what was written. The count keeps only its low CNT_W bits. Config bit 13 is the read-only active flag.
- R3: Each accepted request moves exactly one unit. The channel reads at the source address, then writes the same data to the destination address with `perAck` high in that write cycle, and the count drops by one.
- R4: The config direction field (bits 11:9) sets which address steps. With value 1 (memory to peripheral) the source steps and the destination holds. With value 2 (peripheral to memory) the destination steps and the source holds.
- R5: The width code in control A bits 18:16 (also copied into bits 21:19) gives the unit size: 0, 1 and 2 mean 1, 2 and 4 bytes. The stepping address advances by that size, and `busSize` carries the code.
- R6: When the count reaches zero and the link is non-zero, the channel reads five words at link+0, +4, +8, +12 and +16. It loads them in that order into source, destination, link, control A and count, then continues.
- R7: When the count reaches zero and the link is zero, the channel stops and the enable bit (config bit 0) reads zero.
- R8: A link written by software while a descriptor is running is the one followed when that descriptor finishes.
- R9: A descriptor whose control A bit 31 is set gives exactly one single-cycle `tcPulse` when it finishes. A descriptor with that bit clear gives none.
- R10: While halt (config bit 12) is set, requests are ignored. A unit already started still completes, with active high until it is written, and active then reads zero.
- R11: Clearing enable abandons the current descriptor. Active reads zero from the next cycle, and the abandoned unit produces no write.
- R12: Links that point back to an earlier descriptor make the channel loop around the ring indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| busReq | output | 1 | Bus access request |
| busWe | output | 1 | Bus access is a write |
| busAddr | output | ADDR_W | Bus byte address |
| busSize | output | 2 | Unit width code of the access |
| busWdata | output | 32 | Bus write data |
| busRdata | input | 32 | Bus read data, valid the cycle after a read request |
| perReq | input | 1 | Peripheral transfer request (level) |
| perAck | output | 1 | Peripheral acknowledge, one per unit |
| tcPulse | output | 1 | Terminal-count pulse |

## Verification
The bench uses the default 32-bit address width and narrows the count field to CNT_W=8. A count written with bits above bit 7 therefore comes back truncated, so the field-width edge of R2 is visible at the ports. Short counts of one to five units keep every chain end, chain hop and ring lap within a few dozen cycles. Reaching these in a short run lets the bench drive a single-cycle request pulse exactly one cycle ahead of a halt write or an enable-clear write, and so test the drain and abort timing.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam int DATA_W = 32;

  // register offsets; descriptor word i loads register i
  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_LINK = 3'd2;
  localparam logic [2:0] REG_CTLA = 3'd3;
  localparam logic [2:0] REG_CNT  = 3'd4;
  localparam logic [2:0] REG_CFG  = 3'd5;
  localparam logic [2:0] DESC_LAST = 3'd4;

  // config fields
  localparam int CFG_EN     = 0;
  localparam int CFG_FLOW_LO = 9;
  localparam int CFG_HALT   = 12;
  localparam int CFG_ACTIVE = 13;
  localparam int CFG_KEEP_W = 13;
  localparam logic [2:0] FLOW_M2P = 3'd1;
  localparam logic [2:0] FLOW_P2M = 3'd2;

  // control A fields
  localparam int CTLA_WID_LO = 16;
  localparam int CTLA_IRQ    = 31;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_RD, ST_RDW, ST_WR, ST_DONE, ST_FETCH, ST_FLOAD
  } chState_e;

  typedef enum logic [1:0] {SEL_SRC, SEL_DST, SEL_DESC} busSel_e;

  typedef struct packed {
    logic       capData;
    logic       step;
    logic       decCount;
    logic       latchBase;
    logic       loadWord;
    logic       clrEnable;
    logic [2:0] wordIdx;
    busSel_e    busSel;
  } ctlStrobe_t;
endpackage

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  ctlStrobe_t        strb,
  input  logic              activeIn,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [1:0]        busSize,
  output logic              en,
  output logic              halt,
  output logic              cntZero,
  output logic              nextZero,
  output logic              irqEn
);
  logic [ADDR_W-1:0]     srcReg, dstReg, linkReg, descBase;
  logic [DATA_W-1:0]     ctlA, dataReg;
  logic [CNT_W-1:0]      cntReg;
  logic [CFG_KEEP_W-1:0] cfgReg;
  logic [1:0]            wcode;
  logic [ADDR_W-1:0]     unitStep;
  logic                  srcInc, dstInc;
  logic                  wrSrc, wrDst, wrLink, wrCtlA, wrCnt, wrCfg;

  assign wrSrc  = regWe && (regAddr == REG_SRC);
  assign wrDst  = regWe && (regAddr == REG_DST);
  assign wrLink = regWe && (regAddr == REG_LINK);
  assign wrCtlA = regWe && (regAddr == REG_CTLA);
  assign wrCnt  = regWe && (regAddr == REG_CNT);
  assign wrCfg  = regWe && (regAddr == REG_CFG);

  assign wcode    = (ctlA[CTLA_WID_LO+2] || (ctlA[CTLA_WID_LO+1:CTLA_WID_LO] == 2'd3))
                    ? 2'd2 : ctlA[CTLA_WID_LO+1:CTLA_WID_LO];
  assign unitStep = ADDR_W'(1) << wcode;
  assign srcInc   = cfgReg[CFG_FLOW_LO+2:CFG_FLOW_LO] == FLOW_M2P;
  assign dstInc   = cfgReg[CFG_FLOW_LO+2:CFG_FLOW_LO] == FLOW_P2M;

  assign en       = cfgReg[CFG_EN];
  assign halt     = cfgReg[CFG_HALT];
  assign cntZero  = cntReg == '0;
  assign nextZero = linkReg == '0;
  assign irqEn    = ctlA[CTLA_IRQ];
  assign busWdata = dataReg;
  assign busSize  = wcode;

  always_comb begin
    unique case (strb.busSel)
      SEL_DST:  busAddr = dstReg;
      SEL_DESC: busAddr = descBase + ADDR_W'({strb.wordIdx, 2'b00});
      default:  busAddr = srcReg;
    endcase
  end

  // engine updates of a register win over a software write in the same cycle,
  // except config, where software wins over the chain-end clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg <= '0; dstReg <= '0; linkReg <= '0; descBase <= '0;
      ctlA <= '0; dataReg <= '0; cntReg <= '0; cfgReg <= '0;
    end else begin
      if (strb.capData)   dataReg  <= busRdata;
      if (strb.latchBase) descBase <= linkReg;

      if (strb.loadWord && strb.wordIdx == REG_SRC) srcReg <= ADDR_W'(busRdata);
      else if (strb.step && srcInc)                 srcReg <= srcReg + unitStep;
      else if (wrSrc)                               srcReg <= ADDR_W'(regWdata);

      if (strb.loadWord && strb.wordIdx == REG_DST) dstReg <= ADDR_W'(busRdata);
      else if (strb.step && dstInc)                 dstReg <= dstReg + unitStep;
      else if (wrDst)                               dstReg <= ADDR_W'(regWdata);

      if (strb.loadWord && strb.wordIdx == REG_LINK) linkReg <= ADDR_W'(busRdata);
      else if (wrLink)                               linkReg <= ADDR_W'(regWdata);

      if (strb.loadWord && strb.wordIdx == REG_CTLA) ctlA <= busRdata;
      else if (wrCtlA)                               ctlA <= regWdata;

      if (strb.loadWord && strb.wordIdx == REG_CNT) cntReg <= CNT_W'(busRdata);
      else if (strb.decCount)                       cntReg <= cntReg - CNT_W'(1);
      else if (wrCnt)                               cntReg <= CNT_W'(regWdata);

      if (wrCfg)               cfgReg <= regWdata[CFG_KEEP_W-1:0];
      else if (strb.clrEnable) cfgReg[CFG_EN] <= 1'b0;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_SRC:  regRdata = DATA_W'(srcReg);
      REG_DST:  regRdata = DATA_W'(dstReg);
      REG_LINK: regRdata = DATA_W'(linkReg);
      REG_CTLA: regRdata = ctlA;
      REG_CNT:  regRdata = DATA_W'(cntReg);
      REG_CFG:  regRdata = DATA_W'({activeIn, cfgReg});
      default:  regRdata = '0;
    endcase
  end

  // R3: a unit retires by exactly one count
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCount && !wrCnt |=> cntReg == $past(cntReg) - CNT_W'(1));

  // R4/R5: peripheral-to-memory steps only the destination, by the unit size
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && dstInc && !regWe |=> dstReg == $past(dstReg + unitStep) && $stable(srcReg));

  // R7: the chain-end clear lands in the enable bit
  p_chain_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEnable && !wrCfg |=> !cfgReg[CFG_EN]);
endmodule

// File: rtl/dmaControl.sv
module dmaControl
  import dmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       halt,
  input  logic       cntZero,
  input  logic       nextZero,
  input  logic       irqEn,
  input  logic       perReq,
  output ctlStrobe_t strb,
  output logic       busReq,
  output logic       busWe,
  output logic       perAck,
  output logic       tcPulse,
  output logic       active
);
  chState_e   state, nxt;
  logic [2:0] idxReg;

  always_comb begin
    strb         = '0;
    strb.wordIdx = idxReg;
    strb.busSel  = SEL_SRC;
    busReq  = 1'b0;
    busWe   = 1'b0;
    perAck  = 1'b0;
    tcPulse = 1'b0;
    nxt     = state;
    if (!en) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: nxt = ST_WAIT;
        ST_WAIT: begin
          if (cntZero)              nxt = ST_DONE;
          else if (perReq && !halt) nxt = ST_RD;
        end
        ST_RD: begin
          busReq = 1'b1;
          nxt    = ST_RDW;
        end
        ST_RDW: begin
          strb.capData = 1'b1;
          nxt          = ST_WR;
        end
        ST_WR: begin
          busReq        = 1'b1;
          busWe         = 1'b1;
          perAck        = 1'b1;
          strb.busSel   = SEL_DST;
          strb.step     = 1'b1;
          strb.decCount = 1'b1;
          nxt           = ST_WAIT;
        end
        ST_DONE: begin
          tcPulse = irqEn;
          if (nextZero) begin
            strb.clrEnable = 1'b1;
            nxt            = ST_IDLE;
          end else begin
            strb.latchBase = 1'b1;
            nxt            = ST_FETCH;
          end
        end
        ST_FETCH: begin
          busReq      = 1'b1;
          strb.busSel = SEL_DESC;
          nxt         = ST_FLOAD;
        end
        ST_FLOAD: begin
          strb.loadWord = 1'b1;
          nxt = (idxReg == DESC_LAST) ? ST_WAIT : ST_FETCH;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign active = en && (state != ST_IDLE) && (state != ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idxReg <= '0;
    end else begin
      state <= nxt;
      if (state == ST_DONE)                idxReg <= '0;
      else if (en && state == ST_FLOAD)    idxReg <= idxReg + 3'd1;
    end
  end

  // R10: a halted channel never starts a unit
  p_halt_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WAIT && halt |=> state != ST_RD);

  // R3: one acknowledge per unit, never back to back
  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    perAck |=> !perAck);

  // R9: terminal count is a single-cycle pulse
  p_tc_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |=> !tcPulse);

  // R11: once enable is gone the bus and the peripheral see nothing
  p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(en) |-> !busReq && !perAck && !active);
endmodule

// File: rtl/llDmaChannel.sv
module llDmaChannel
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  input  logic              perReq,
  output logic              perAck,
  output logic              tcPulse
);
  ctlStrobe_t strb;
  logic en, halt, cntZero, nextZero, irqEn, active;

  dmaControl ctrl_i (
    .clk(clk), .rstN(rstN), .en(en), .halt(halt), .cntZero(cntZero),
    .nextZero(nextZero), .irqEn(irqEn), .perReq(perReq), .strb(strb),
    .busReq(busReq), .busWe(busWe), .perAck(perAck), .tcPulse(tcPulse),
    .active(active)
  );

  dmaDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .activeIn(active),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .busSize(busSize), .en(en), .halt(halt), .cntZero(cntZero),
    .nextZero(nextZero), .irqEn(irqEn)
  );
endmodule

// File: tb/llDmaChannel_tb_top.sv
module llDmaChannel_tb_top;
  localparam int AW = 32;
  localparam logic [2:0] A_SRC = 3'd0, A_DST = 3'd1, A_LINK = 3'd2,
                         A_CTLA = 3'd3, A_CNT = 3'd4, A_CFG = 3'd5;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic busReq, busWe, perAck, tcPulse;
  logic [AW-1:0] busAddr;
  logic [1:0] busSize;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic perReq = 1'b0;

  logic [31:0] mem [0:511];
  expItem_t expQ[$];
  int total = 0, bad = 0, popCount = 0, tcCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  llDmaChannel #(.ADDR_W(AW), .CNT_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .perReq(perReq), .perAck(perAck), .tcPulse(tcPulse)
  );

  always @(posedge clk) if (busReq && !busWe) busRdata <= mem[busAddr[10:2]];

  // monitor: every bus write is one retired unit
  always @(negedge clk) begin
    if (rstN && tcPulse) tcCount++;
    if (rstN && busReq && busWe) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R3: unexpected write addr=%h data=%h exp none", busAddr, busWdata);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (busAddr != e.addr || busWdata != e.data || busSize != e.size || !perAck) begin
          bad++;
          $display("FAIL R3/R5: write got a=%h d=%h s=%0d ack=%b exp a=%h d=%h s=%0d ack=1",
                   busAddr, busWdata, busSize, perAck, e.addr, e.data, e.size);
        end
      end
      popCount++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  task automatic pushUnit(logic [31:0] a, logic [31:0] d, logic [1:0] s);
    expItem_t e;
    e.addr = a; e.data = d; e.size = s;
    expQ.push_back(e);
  endtask

  // called at a falling edge, returns at a falling edge
  task automatic wrReg(logic [2:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic prog(logic [31:0] s, logic [31:0] d, logic [31:0] l, logic [31:0] c, logic [31:0] n);
    wrReg(A_SRC, s); wrReg(A_DST, d); wrReg(A_LINK, l); wrReg(A_CTLA, c); wrReg(A_CNT, n);
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rdReg(A_CFG, v);
      if (!v[0]) break;
    end
  endtask

  function automatic logic [31:0] ctlA(logic [1:0] w, logic irq);
    return (32'(irq) << 31) | (32'(w) << 19) | (32'(w) << 16);
  endfunction

  function automatic logic [31:0] cfg(logic en, logic [2:0] flow, logic hlt);
    return 32'(en) | (32'(flow) << 9) | (32'(hlt) << 12) | (32'd3 << 1);
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish();
  end

  initial begin
    logic [31:0] v;
    int tc0;
    for (int i = 0; i < 512; i++) mem[i] = {8'hA5, 8'(i), 16'(i * 13 + 7)};
    // descriptor D1 at 0x400: src 0x240, dst 0x3E0, link 0, width 4 bytes, irq, count 2
    mem[256] = 32'h240; mem[257] = 32'h3E0; mem[258] = 32'h0;
    mem[259] = ctlA(2, 1); mem[260] = 32'd2;
    // ring: RA at 0x440 -> RB at 0x460 -> RA
    mem[272] = 32'h260; mem[273] = 32'h3D0; mem[274] = 32'h460;
    mem[275] = ctlA(2, 1); mem[276] = 32'd1;
    mem[280] = 32'h270; mem[281] = 32'h3D0; mem[282] = 32'h440;
    mem[283] = ctlA(2, 1); mem[284] = 32'd1;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rdReg(3'(a), v);
      check("R1 reg", v, 32'h0);
    end
    check("R1 outputs", {29'h0, busReq, perAck, tcPulse}, 32'h0);

    // R2: readback and count truncation, config keeps halt and reads active 0
    @(negedge clk);
    prog(32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 32'hDEAD_BEEF, 32'h0000_0123);
    wrReg(A_CFG, 32'h0000_1FFE);
    rdReg(A_SRC, v);  check("R2 src", v, 32'h1122_3344);
    rdReg(A_DST, v);  check("R2 dst", v, 32'h5566_7788);
    rdReg(A_LINK, v); check("R2 link", v, 32'h99AA_BBCC);
    rdReg(A_CTLA, v); check("R2 ctlA", v, 32'hDEAD_BEEF);
    rdReg(A_CNT, v);  check("R2 count", v, 32'h23);
    rdReg(A_CFG, v);  check("R2 cfg", v, 32'h1FFE);
    @(negedge clk);
    wrReg(A_CFG, 32'h0);

    // R3 R4 R7 R9: memory to peripheral, 4-byte units, single descriptor
    tc0 = tcCount;
    for (int i = 0; i < 3; i++) pushUnit(32'h3F0, mem[128 + i], 2'd2);
    prog(32'h200, 32'h3F0, 32'h0, ctlA(2, 1), 32'd3);
    perReq = 1'b1;
    wrReg(A_CFG, cfg(1, 1, 0));
    waitIdle();
    rdReg(A_SRC, v); check("R4 src stepped", v, 32'h20C);
    rdReg(A_DST, v); check("R4 dst held", v, 32'h3F0);
    rdReg(A_CNT, v); check("R3 count", v, 32'h0);
    rdReg(A_CFG, v); check("R7 enable cleared", {31'h0, v[0]}, 32'h0);
    check("R9 one pulse", 32'(tcCount - tc0), 32'd1);
    check("R3 queue drained", 32'(expQ.size()), 32'd0);

    // R5: peripheral to memory, byte units, no pulse
    tc0 = tcCount;
    @(negedge clk);
    for (int i = 0; i < 3; i++) pushUnit(32'h300 + 32'(i), mem[64], 2'd0);
    prog(32'h100, 32'h300, 32'h0, ctlA(0, 0), 32'd3);
    wrReg(A_CFG, cfg(1, 2, 0));
    waitIdle();
    rdReg(A_DST, v); check("R5 dst byte step", v, 32'h303);
    rdReg(A_SRC, v); check("R4 src held", v, 32'h100);
    check("R9 no pulse", 32'(tcCount - tc0), 32'd0);

    // R5: half-word units
    @(negedge clk);
    pushUnit(32'h310, mem[64], 2'd1);
    pushUnit(32'h312, mem[64], 2'd1);
    prog(32'h100, 32'h310, 32'h0, ctlA(1, 0), 32'd2);
    wrReg(A_CFG, cfg(1, 2, 0));
    waitIdle();
    rdReg(A_DST, v); check("R5 dst half step", v, 32'h314);

    // R6: one direct unit then a fetched descriptor
    tc0 = tcCount;
    @(negedge clk);
    pushUnit(32'h3F0, mem[140], 2'd2);
    pushUnit(32'h3E0, mem[144], 2'd2);
    pushUnit(32'h3E0, mem[145], 2'd2);
    prog(32'h230, 32'h3F0, 32'h400, ctlA(2, 1), 32'd1);
    wrReg(A_CFG, cfg(1, 1, 0));
    waitIdle();
    rdReg(A_SRC, v);  check("R6 src loaded", v, 32'h248);
    rdReg(A_LINK, v); check("R6 link loaded", v, 32'h0);
    rdReg(A_CTLA, v); check("R6 ctlA loaded", v, ctlA(2, 1));
    check("R9 two pulses", 32'(tcCount - tc0), 32'd2);
    check("R6 queue drained", 32'(expQ.size()), 32'd0);

    // R8: link rewritten while running
    tc0 = tcCount;
    perReq = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) pushUnit(32'h3C0, mem[160 + i], 2'd2);
    pushUnit(32'h3E0, mem[144], 2'd2);
    pushUnit(32'h3E0, mem[145], 2'd2);
    prog(32'h280, 32'h3C0, 32'h0, ctlA(2, 0), 32'd4);
    wrReg(A_CFG, cfg(1, 1, 0));
    repeat (3) @(negedge clk);
    wrReg(A_LINK, 32'h400);
    perReq = 1'b1;
    waitIdle();
    check("R8 followed new link", 32'(expQ.size()), 32'd0);
    check("R8 pulse from second", 32'(tcCount - tc0), 32'd1);

    // R10: halt drains the unit in flight, then ignores requests
    perReq = 1'b0;
    @(negedge clk);
    prog(32'h2A0, 32'h3B0, 32'h0, ctlA(2, 0), 32'd5);
    wrReg(A_CFG, cfg(1, 1, 0));
    repeat (3) @(negedge clk);
    pushUnit(32'h3B0, mem[168], 2'd2);
    perReq = 1'b1;
    @(negedge clk);
    perReq = 1'b0;
    wrReg(A_CFG, cfg(1, 1, 1));
    rdReg(A_CFG, v); check("R10 active in flight", {31'h0, v[13]}, 32'h1);
    repeat (4) @(negedge clk);
    rdReg(A_CFG, v); check("R10 active drained", {31'h0, v[13]}, 32'h0);
    perReq = 1'b1;
    repeat (20) @(negedge clk);
    rdReg(A_CNT, v); check("R10 requests ignored", v, 32'd4);
    perReq = 1'b0;
    wrReg(A_CFG, 32'h0);

    // R11: clearing enable abandons the started unit
    prog(32'h2A0, 32'h3B0, 32'h0, ctlA(2, 0), 32'd5);
    wrReg(A_CFG, cfg(1, 1, 0));
    repeat (3) @(negedge clk);
    perReq = 1'b1;
    @(negedge clk);
    perReq = 1'b0;
    wrReg(A_CFG, cfg(0, 1, 0));
    rdReg(A_CFG, v); check("R11 active dropped", {31'h0, v[13]}, 32'h0);
    repeat (10) @(negedge clk);
    rdReg(A_CNT, v); check("R11 count untouched", v, 32'd5);
    check("R11 no write", 32'(expQ.size()), 32'd0);

    // R12: two-descriptor ring
    tc0 = tcCount;
    for (int k = 0; k < 2; k++) begin
      pushUnit(32'h3D0, mem[152], 2'd2);
      pushUnit(32'h3D0, mem[156], 2'd2);
    end
    prog(32'h260, 32'h3D0, 32'h460, ctlA(2, 1), 32'd1);
    v = 32'(popCount);
    perReq = 1'b1;
    wrReg(A_CFG, cfg(1, 1, 0));
    wait (popCount == int'(v) + 4);
    perReq = 1'b0;
    repeat (20) @(negedge clk);
    rdReg(A_SRC, v);  check("R12 looped to first", v, 32'h260);
    rdReg(A_LINK, v); check("R12 link to second", v, 32'h460);
    rdReg(A_CNT, v);  check("R12 count reloaded", v, 32'd1);
    check("R12 four pulses", 32'(tcCount - tc0), 32'd4);
    wrReg(A_CFG, 32'h0);
    repeat (5) @(negedge clk);
    check("R12 queue drained", 32'(expQ.size()), 32'd0);

    finish();
  end
endmodule